// File: doc/BRIEF.md
# Set-Associative Data Translation Cache

This block holds recently completed address translations for data accesses so that a load or store can find its physical page without walking the page tables. A requester presents an effective page number on the lookup port and, in the same cycle, gets back a hit flag, the physical page number and the permission bits. On a miss, the block raises a walk request instead. When the page walker has built a translation, it writes it through the fill port. An invalidate port takes the register operand of a translation-invalidate instruction. It either wipes the whole structure or drops a single page, depending on how that operand is encoded.

The storage is organised as `SETS` sets of `WAYS` ways. The set index is the low bits of the effective page number, and the tag is the rest. Each set has its own replacement state, so that two pages that share a set can stay resident together. Lookup is purely combinational over registered entries. Fills and invalidations take effect at the next clock edge.

Top module: `dtlb_sa`

## Requirements
- R1: After reset, every entry is invalid, and any lookup misses until a fill has been made.
- R2: When `lk_valid` is high and a valid entry in set `lk_epn[IDX_W-1:0]` holds tag `lk_epn[EPN_W-1:IDX_W]`, `lk_hit` is 1 in the same cycle and `lk_ppn`/`lk_perm` carry that entry. Otherwise `lk_hit` is 0, `lk_ppn` and `lk_perm` are zero, and `lk_miss` equals `lk_valid`.
- R3: An accepted fill writes its entry at the next rising edge, and a lookup of the same page in the following cycle hits with the filled PPN and permissions.
- R4: Two pages that share a set and differ only in tag, such as effective addresses 0x124000 and 0x1124000 (page numbers 0x124 and 0x1124), are both resident after being filled one after the other.
- R5: A fill goes to the way that already holds its page if one exists. Otherwise it goes to the lowest-numbered invalid way in the set. Otherwise it goes to the way named by the set's replacement state.
- R6: With two ways, each set has one replacement bit. A lookup hit on way w, or a fill into way w, sets it to the other way. If a fill and a lookup hit touch the same set in one cycle, the fill's update wins.
- R7: An invalidate whose operand equals 0xC00 clears every entry.
- R8: An invalidate whose operand has bits 11:0 all zero, and is not 0xC00, removes only the entry whose page number equals operand bits 30:12. Other pages stay resident.
- R9: An invalidate whose operand is neither 0xC00 nor has bits 11:0 zero leaves every entry unchanged.
- R10: A fill presented in a cycle where `inv_valid` is high is discarded.
- R11: A lookup made in the same cycle as an invalidate sees the contents from before the invalidate.
- R12: At most one way of a set ever matches a given page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_epn | input | EPN_W | Effective page number to translate |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Lookup missed; start a walk |
| lk_ppn | output | PPN_W | Physical page number on hit, else 0 |
| lk_perm | output | PERM_W | Permission and attribute bits on hit, else 0 |
| fill_valid | input | 1 | Write a translation from the walker |
| fill_epn | input | EPN_W | Page number being filled |
| fill_ppn | input | PPN_W | Physical page number being filled |
| fill_perm | input | PERM_W | Permission bits being filled |
| inv_valid | input | 1 | Invalidate request |
| inv_rb | input | RB_W | Invalidate operand |

## Verification
The clocked properties assume that `lk_epn`, `fill_epn` and `inv_rb` are known whenever their valid bits are high. They also assume that the lookup port reads state as of the start of the cycle, so a fill in cycle n is first visible in cycle n+1. The stimulus drives all inputs at the falling edge and keeps them stable through the rising edge. It uses a small pool of page numbers that collide in one set, so replacement, duplicate refills and collisions between invalidate and fill happen often. Invalidate operands are drawn only from the three encodings: the wipe-all code, page-aligned addresses and misaligned values.

// File: rtl/dtlb_sa_pkg.sv
`timescale 1ns/1ps
package dtlb_sa_pkg;

   // Decoded meaning of an invalidate operand
   typedef enum logic [1:0] {
      INV_NONE = 2'd0,
      INV_ALL  = 2'd1,
      INV_PAGE = 2'd2
   } inv_kind_e;

   // Width of an index that must be at least one bit wide
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/dtlb_inv_decode.sv
`timescale 1ns/1ps
module dtlb_inv_decode
   import dtlb_sa_pkg::*;
#(
   parameter int unsigned RB_W       = 64,
   parameter int unsigned EPN_W      = 19,
   parameter int unsigned PAGE_SHIFT = 12,
   parameter int unsigned ALL_CODE   = 32'hC00
) (
   input  logic             req,
   input  logic [RB_W-1:0]  operand,
   output inv_kind_e        kind,
   output logic [EPN_W-1:0] page
);

   if (PAGE_SHIFT + EPN_W > RB_W) begin : g_bad_width
      $error("dtlb_inv_decode: operand too narrow for page field");
   end

   localparam logic [RB_W-1:0] ALL_VAL = RB_W'(ALL_CODE);

   always_comb begin
      kind = INV_NONE;
      if (req) begin
         if (operand == ALL_VAL) begin
            kind = INV_ALL;
         end else if (operand[PAGE_SHIFT-1:0] == '0) begin
            kind = INV_PAGE;
         end
      end
   end

   assign page = operand[PAGE_SHIFT +: EPN_W];

endmodule

// File: rtl/dtlb_way_store.sv
`timescale 1ns/1ps
module dtlb_way_store #(
   parameter int unsigned SETS   = 16,
   parameter int unsigned TAG_W  = 15,
   parameter int unsigned PPN_W  = 36,
   parameter int unsigned PERM_W = 8,
   localparam int unsigned IDX_W = $clog2(SETS)
) (
   input  logic              clk,
   input  logic              rst_n,
   // lookup compare
   input  logic [IDX_W-1:0]  lk_idx,
   input  logic [TAG_W-1:0]  lk_tag,
   output logic              lk_match,
   output logic [PPN_W-1:0]  lk_ppn,
   output logic [PERM_W-1:0] lk_perm,
   // fill compare and write
   input  logic [IDX_W-1:0]  fl_idx,
   input  logic [TAG_W-1:0]  fl_tag,
   output logic              fl_match,
   output logic              fl_used,
   input  logic              wr_en,
   input  logic [PPN_W-1:0]  wr_ppn,
   input  logic [PERM_W-1:0] wr_perm,
   // invalidation
   input  logic [IDX_W-1:0]  iv_idx,
   input  logic [TAG_W-1:0]  iv_tag,
   input  logic              clr_all,
   input  logic              clr_page
);

   logic [SETS-1:0]   valid_q;
   logic [TAG_W-1:0]  tag_q  [SETS];
   logic [PPN_W-1:0]  ppn_q  [SETS];
   logic [PERM_W-1:0] perm_q [SETS];

   logic iv_match;

   assign lk_match = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
   assign lk_ppn   = ppn_q[lk_idx];
   assign lk_perm  = perm_q[lk_idx];
   assign fl_used  = valid_q[fl_idx];
   assign fl_match = valid_q[fl_idx] && (tag_q[fl_idx] == fl_tag);
   assign iv_match = valid_q[iv_idx] && (tag_q[iv_idx] == iv_tag);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (clr_all) begin
         valid_q <= '0;
      end else begin
         if (clr_page && iv_match) begin
            valid_q[iv_idx] <= 1'b0;
         end
         if (wr_en) begin
            valid_q[fl_idx] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[fl_idx]  <= fl_tag;
         ppn_q[fl_idx]  <= wr_ppn;
         perm_q[fl_idx] <= wr_perm;
      end
   end

   // R7: a wipe leaves the entry looked up next cycle empty
   p_wipe_way_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> !valid_q[lk_idx]);

   // R5: a written slot is valid afterwards
   p_write_sets_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr_all) |=> valid_q[$past(fl_idx)]);

endmodule

// File: rtl/dtlb_repl.sv
`timescale 1ns/1ps
module dtlb_repl
   import dtlb_sa_pkg::*;
#(
   parameter int unsigned SETS = 16,
   parameter int unsigned WAYS = 2,
   localparam int unsigned IDX_W = $clog2(SETS),
   localparam int unsigned WAY_W = idx_bits(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_upd,
   input  logic [IDX_W-1:0] hit_idx,
   input  logic [WAY_W-1:0] hit_way,
   input  logic             fl_upd,
   input  logic [IDX_W-1:0] fl_idx,
   input  logic [WAY_W-1:0] fl_way,
   output logic [WAY_W-1:0] vic_way
);

   if (WAYS < 2) begin : g_bad_ways
      $error("dtlb_repl: needs at least two ways");
   end

   if (WAYS == 2) begin : g_lru_bit
      logic [SETS-1:0] lru_q;

      assign vic_way = lru_q[fl_idx];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lru_q <= '0;
         end else begin
            if (hit_upd) lru_q[hit_idx] <= ~hit_way[0];
            if (fl_upd)  lru_q[fl_idx]  <= ~fl_way[0];
         end
      end

      // R6: after a fill the set points away from the filled way
      p_lru_away_r6: assert property (@(posedge clk) disable iff (!rst_n)
         fl_upd |=> (lru_q[$past(fl_idx)] != $past(fl_way[0])));

      // R6: a hit alone moves the pointer to the other way
      p_hit_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (hit_upd && !(fl_upd && fl_idx == hit_idx))
            |=> (lru_q[$past(hit_idx)] != $past(hit_way[0])));
   end else begin : g_round_robin
      logic [WAY_W-1:0] ptr_q [SETS];

      function automatic logic [WAY_W-1:0] bump(input logic [WAY_W-1:0] p);
         return (p == WAY_W'(WAYS - 1)) ? '0 : p + 1'b1;
      endfunction

      assign vic_way = ptr_q[fl_idx];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
         end else begin
            if (hit_upd && hit_way == ptr_q[hit_idx]) begin
               ptr_q[hit_idx] <= bump(ptr_q[hit_idx]);
            end
            if (fl_upd && fl_way == ptr_q[fl_idx]) begin
               ptr_q[fl_idx] <= bump(ptr_q[fl_idx]);
            end
         end
      end
   end

endmodule

// File: rtl/dtlb_sa.sv
`timescale 1ns/1ps
module dtlb_sa
   import dtlb_sa_pkg::*;
#(
   parameter int unsigned EPN_W         = 19,
   parameter int unsigned PPN_W         = 36,
   parameter int unsigned PERM_W        = 8,
   parameter int unsigned SETS          = 16,
   parameter int unsigned WAYS          = 2,
   parameter int unsigned RB_W          = 64,
   parameter int unsigned PAGE_SHIFT    = 12,
   parameter int unsigned INV_ALL_CODE  = 32'hC00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [EPN_W-1:0]  lk_epn,
   output logic              lk_hit,
   output logic              lk_miss,
   output logic [PPN_W-1:0]  lk_ppn,
   output logic [PERM_W-1:0] lk_perm,
   input  logic              fill_valid,
   input  logic [EPN_W-1:0]  fill_epn,
   input  logic [PPN_W-1:0]  fill_ppn,
   input  logic [PERM_W-1:0] fill_perm,
   input  logic              inv_valid,
   input  logic [RB_W-1:0]   inv_rb
);

   localparam int unsigned IDX_W = $clog2(SETS);
   localparam int unsigned TAG_W = EPN_W - IDX_W;
   localparam int unsigned WAY_W = idx_bits(WAYS);

   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("dtlb_sa: SETS must be a power of two, at least 2");
   end
   if (EPN_W <= IDX_W) begin : g_bad_epn
      $error("dtlb_sa: page number narrower than set index");
   end

   // ---------------- address split ----------------
   logic [IDX_W-1:0] lk_idx, fl_idx, iv_idx;
   logic [TAG_W-1:0] lk_tag, fl_tag, iv_tag;
   logic [EPN_W-1:0] iv_page;
   inv_kind_e        iv_kind;

   assign lk_idx = lk_epn[IDX_W-1:0];
   assign lk_tag = lk_epn[EPN_W-1:IDX_W];
   assign fl_idx = fill_epn[IDX_W-1:0];
   assign fl_tag = fill_epn[EPN_W-1:IDX_W];
   assign iv_idx = iv_page[IDX_W-1:0];
   assign iv_tag = iv_page[EPN_W-1:IDX_W];

   dtlb_inv_decode #(
      .RB_W       (RB_W),
      .EPN_W      (EPN_W),
      .PAGE_SHIFT (PAGE_SHIFT),
      .ALL_CODE   (INV_ALL_CODE)
   ) u_inv_decode (
      .req     (inv_valid),
      .operand (inv_rb),
      .kind    (iv_kind),
      .page    (iv_page)
   );

   logic fill_go;
   logic clr_all, clr_page;
   assign fill_go  = fill_valid && !inv_valid;
   assign clr_all  = (iv_kind == INV_ALL);
   assign clr_page = (iv_kind == INV_PAGE);

   // ---------------- ways ----------------
   logic [WAYS-1:0]   lk_match_v, fl_match_v, fl_used_v;
   logic [PPN_W-1:0]  way_ppn  [WAYS];
   logic [PERM_W-1:0] way_perm [WAYS];
   logic [WAY_W-1:0]  fl_way, vic_way, hit_way;

   for (genvar g = 0; g < WAYS; g++) begin : g_way
      dtlb_way_store #(
         .SETS   (SETS),
         .TAG_W  (TAG_W),
         .PPN_W  (PPN_W),
         .PERM_W (PERM_W)
      ) u_store (
         .clk      (clk),
         .rst_n    (rst_n),
         .lk_idx   (lk_idx),
         .lk_tag   (lk_tag),
         .lk_match (lk_match_v[g]),
         .lk_ppn   (way_ppn[g]),
         .lk_perm  (way_perm[g]),
         .fl_idx   (fl_idx),
         .fl_tag   (fl_tag),
         .fl_match (fl_match_v[g]),
         .fl_used  (fl_used_v[g]),
         .wr_en    (fill_go && (fl_way == WAY_W'(g))),
         .wr_ppn   (fill_ppn),
         .wr_perm  (fill_perm),
         .iv_idx   (iv_idx),
         .iv_tag   (iv_tag),
         .clr_all  (clr_all),
         .clr_page (clr_page)
      );
   end

   // ---------------- lookup result ----------------
   always_comb begin
      hit_way = '0;
      lk_ppn  = '0;
      lk_perm = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (lk_valid && lk_match_v[w]) begin
            hit_way = WAY_W'(w);
            lk_ppn  = way_ppn[w];
            lk_perm = way_perm[w];
         end
      end
   end

   assign lk_hit  = lk_valid && (|lk_match_v);
   assign lk_miss = lk_valid && !(|lk_match_v);

   // ---------------- fill way choice ----------------
   always_comb begin
      logic found_match;
      logic found_free;
      logic [WAY_W-1:0] match_way;
      logic [WAY_W-1:0] free_way;
      found_match = 1'b0;
      found_free  = 1'b0;
      match_way   = '0;
      free_way    = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (!found_match && fl_match_v[w]) begin
            found_match = 1'b1;
            match_way   = WAY_W'(w);
         end
         if (!found_free && !fl_used_v[w]) begin
            found_free = 1'b1;
            free_way   = WAY_W'(w);
         end
      end
      if (found_match)     fl_way = match_way;
      else if (found_free) fl_way = free_way;
      else                 fl_way = vic_way;
   end

   dtlb_repl #(
      .SETS (SETS),
      .WAYS (WAYS)
   ) u_repl (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_upd (lk_hit),
      .hit_idx (lk_idx),
      .hit_way (hit_way),
      .fl_upd  (fill_go),
      .fl_idx  (fl_idx),
      .fl_way  (fl_way),
      .vic_way (vic_way)
   );

   // ---------------- properties ----------------
   // R12: never two ways holding the same page
   p_single_match_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match_v));

   // R2: a miss returns zero payload
   p_miss_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_miss |-> (lk_ppn == '0 && lk_perm == '0 && !lk_hit));

   // R3: a fill is visible to a lookup of the same page next cycle
   p_fill_seen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && !inv_valid) |=>
         (!lk_valid || lk_epn != $past(fill_epn)
          || (lk_hit && lk_ppn == $past(fill_ppn))));

   // R7: wipe-all code leaves nothing to hit
   p_wipe_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && inv_rb == RB_W'(INV_ALL_CODE)) |=> !lk_hit);

   // R8: a page-aligned operand removes that page
   p_page_gone_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && inv_rb[PAGE_SHIFT-1:0] == '0) |=>
         (!lk_valid || lk_epn != $past(inv_rb[PAGE_SHIFT +: EPN_W]) || !lk_hit));

endmodule

// File: tb/dtlb_sa_bench.sv
`timescale 1ns/1ps
module dtlb_sa_bench;

   localparam int EPN_W  = 19;
   localparam int PPN_W  = 36;
   localparam int PERM_W = 8;
   localparam int SETS   = 16;
   localparam int WAYS   = 2;
   localparam int RB_W   = 64;
   localparam int IDX_W  = 4;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              lk_valid;
   logic [EPN_W-1:0]  lk_epn;
   logic              lk_hit, lk_miss;
   logic [PPN_W-1:0]  lk_ppn;
   logic [PERM_W-1:0] lk_perm;
   logic              fill_valid;
   logic [EPN_W-1:0]  fill_epn;
   logic [PPN_W-1:0]  fill_ppn;
   logic [PERM_W-1:0] fill_perm;
   logic              inv_valid;
   logic [RB_W-1:0]   inv_rb;

   always #10 clk = ~clk;   // 50 MHz

   dtlb_sa u_dtlb_sa (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_epn(lk_epn), .lk_hit(lk_hit), .lk_miss(lk_miss),
      .lk_ppn(lk_ppn), .lk_perm(lk_perm),
      .fill_valid(fill_valid), .fill_epn(fill_epn), .fill_ppn(fill_ppn),
      .fill_perm(fill_perm), .inv_valid(inv_valid), .inv_rb(inv_rb)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   // reference model state
   bit                m_v    [SETS][WAYS];
   logic [EPN_W-1:0]  m_page [SETS][WAYS];
   logic [PPN_W-1:0]  m_ppn  [SETS][WAYS];
   logic [PERM_W-1:0] m_perm [SETS][WAYS];
   int                m_lru  [SETS];

   logic              got_hit;
   logic [PPN_W-1:0]  got_ppn;

   task automatic model_clear();
      for (int s = 0; s < SETS; s++) begin
         m_lru[s] = 0;
         for (int w = 0; w < WAYS; w++) m_v[s][w] = 0;
      end
   endtask

   task automatic fail(input string tag, input string what);
      bad++;
      $display("FAIL %s: %s", tag, what);
   endtask

   // One clock: drive at falling edge, compare, then advance the model
   task automatic step(input string tag,
                       input bit lv, input logic [EPN_W-1:0] le,
                       input bit fv, input logic [EPN_W-1:0] fe,
                       input logic [PPN_W-1:0] fp, input logic [PERM_W-1:0] fm,
                       input bit iv, input logic [RB_W-1:0] rb);
      int ls, fs, hw, fw;
      bit eh;
      logic [PPN_W-1:0]  ep;
      logic [PERM_W-1:0] em;
      @(negedge clk);
      lk_valid = lv; lk_epn = le;
      fill_valid = fv; fill_epn = fe; fill_ppn = fp; fill_perm = fm;
      inv_valid = iv; inv_rb = rb;
      #2;
      ls = int'(le) % SETS;
      eh = 0; hw = 0; ep = '0; em = '0;
      if (lv) begin
         for (int w = 0; w < WAYS; w++) begin
            if (m_v[ls][w] && m_page[ls][w] == le) begin
               eh = 1; hw = w; ep = m_ppn[ls][w]; em = m_perm[ls][w];
            end
         end
      end
      total++;
      if (lk_hit !== eh || lk_miss !== (lv && !eh) || lk_ppn !== ep || lk_perm !== em)
         fail(tag, $sformatf("epn=%h hit=%b miss=%b ppn=%h perm=%h expected hit=%b miss=%b ppn=%h perm=%h",
              le, lk_hit, lk_miss, lk_ppn, lk_perm, eh, lv && !eh, ep, em));
      got_hit = lk_hit;
      got_ppn = lk_ppn;
      @(posedge clk);
      // fill target chosen from state before this edge
      fs = int'(fe) % SETS;
      fw = -1;
      for (int w = 0; w < WAYS; w++)
         if (fw < 0 && m_v[fs][w] && m_page[fs][w] == fe) fw = w;
      for (int w = 0; w < WAYS; w++)
         if (fw < 0 && !m_v[fs][w]) fw = w;
      if (fw < 0) fw = m_lru[fs];
      if (iv) begin
         if (rb == 64'hC00) begin
            for (int s = 0; s < SETS; s++)
               for (int w = 0; w < WAYS; w++) m_v[s][w] = 0;
         end else if (rb[11:0] == 12'h0) begin
            int is;
            is = int'(rb[30:12]) % SETS;
            for (int w = 0; w < WAYS; w++)
               if (m_page[is][w] == rb[30:12]) m_v[is][w] = 0;
         end
      end
      if (eh) m_lru[ls] = 1 - hw;
      if (fv && !iv) begin
         m_v[fs][fw] = 1; m_page[fs][fw] = fe;
         m_ppn[fs][fw] = fp; m_perm[fs][fw] = fm;
         m_lru[fs] = 1 - fw;
      end
   endtask

   task automatic look(input string tag, input logic [EPN_W-1:0] e,
                       input bit exp_hit, input logic [PPN_W-1:0] exp_ppn);
      step(tag, 1, e, 0, '0, '0, '0, 0, '0);
      total++;
      if (got_hit !== exp_hit || (exp_hit && got_ppn !== exp_ppn))
         fail(tag, $sformatf("epn=%h hit=%b ppn=%h expected hit=%b ppn=%h",
              e, got_hit, got_ppn, exp_hit, exp_ppn));
   endtask

   task automatic fill(input string tag, input logic [EPN_W-1:0] e,
                       input logic [PPN_W-1:0] p, input logic [PERM_W-1:0] m);
      step(tag, 0, '0, 1, e, p, m, 0, '0);
   endtask

   task automatic inval(input string tag, input logic [RB_W-1:0] rb);
      step(tag, 0, '0, 0, '0, '0, '0, 1, rb);
   endtask

   localparam logic [EPN_W-1:0] PA = 19'h00124;
   localparam logic [EPN_W-1:0] PB = 19'h01124;
   localparam logic [EPN_W-1:0] PC = 19'h02124;
   localparam logic [EPN_W-1:0] PD = 19'h03124;
   localparam logic [EPN_W-1:0] PE = 19'h04124;
   localparam logic [EPN_W-1:0] PF = 19'h00125;

   initial begin
      rst_n = 0;
      lk_valid = 0; lk_epn = '0; fill_valid = 0; fill_epn = '0;
      fill_ppn = '0; fill_perm = '0; inv_valid = 0; inv_rb = '0;
      model_clear();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;

      look("R1", PA, 0, '0);
      look("R1", 19'h7ffff, 0, '0);

      fill("R3", PA, 36'h4, 8'h86);
      look("R3", PA, 1, 36'h4);
      fill("R4", PB, 36'h5, 8'h86);
      look("R4", PB, 1, 36'h5);
      look("R4", PA, 1, 36'h4);

      // replacement: A was touched last, so B goes
      fill("R5", PC, 36'h6, 8'h84);
      look("R6", PB, 0, '0);
      look("R5", PA, 1, 36'h4);
      look("R5", PC, 1, 36'h6);

      // duplicate refill overwrites in place
      fill("R5", PA, 36'h7, 8'h86);
      look("R12", PA, 1, 36'h7);
      look("R12", PC, 1, 36'h6);

      // fill and hit in one set: fill's pointer update wins
      step("R6", 1, PC, 1, PD, 36'h8, 8'h86, 0, '0);
      fill("R6", PE, 36'h9, 8'h86);
      look("R6", PC, 0, '0);
      look("R6", PD, 1, 36'h8);
      look("R6", PE, 1, 36'h9);

      // single-page invalidate
      inval("R8", 64'h3124000);
      look("R8", PD, 0, '0);
      look("R8", PE, 1, 36'h9);

      // misaligned operand does nothing
      inval("R9", 64'h4124008);
      look("R9", PE, 1, 36'h9);

      // fill discarded under invalidate
      step("R10", 0, '0, 1, PF, 36'hA, 8'h86, 1, 64'h1);
      look("R10", PF, 0, '0);
      fill("R3", PF, 36'hB, 8'h06);
      look("R3", PF, 1, 36'hB);

      // lookup sees old contents in the wipe cycle
      step("R11", 1, PE, 0, '0, '0, '0, 1, 64'hC00);
      total++;
      if (got_hit !== 1'b1)
         fail("R11", $sformatf("hit=%b expected hit=1", got_hit));
      look("R7", PE, 0, '0);
      look("R7", PF, 0, '0);

      // mixed traffic against the model
      for (int i = 0; i < 800; i++) begin
         logic [EPN_W-1:0] pool [6];
         logic [EPN_W-1:0] le, fe;
         logic [RB_W-1:0]  rb;
         int r;
         pool[0] = PA; pool[1] = PB; pool[2] = PC;
         pool[3] = PD; pool[4] = PF; pool[5] = 19'h7ffff;
         le = pool[$urandom_range(5)];
         fe = pool[$urandom_range(5)];
         r  = $urandom_range(19);
         if (r == 0)      rb = 64'hC00;
         else if (r < 3)  rb = {33'h0, pool[$urandom_range(5)], 12'h0};
         else             rb = {33'h0, pool[$urandom_range(5)], 12'h010};
         step("R2", $urandom_range(3) != 0, le,
              $urandom_range(2) == 0, fe, 36'($urandom), 8'($urandom),
              $urandom_range(7) == 0, rb);
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule